// File: doc/BRIEF.md
# Compare-Match Timer Channel

One 32-bit timer channel with a small word-addressed register bus. A counter advances on enable pulses from a prescaler. The prescaler divides a slow reference tick, which arrives as a one-cycle pulse in the system clock domain. An external run bit, taken from a start/stop register that several channels share, gates the counter. When the counter reaches the compare value, the channel sets a sticky match flag. In periodic mode it also restarts the count from zero. Depending on the configured request kind, it then holds an interrupt line high or emits a one-cycle DMA request strobe.

Software sets a compare value, picks a divide ratio and a request kind, and sets the run bit. Counter writes do not land at once. The write is staged and applied on the second reference tick that follows it, which models the slow counting domain. Until then, a read of the counter returns the old value. Flags are cleared by writing zero to their bit positions.

Top module: `cmt_channel`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, the compare register reads all ones, and `irq` and `dma_req` are low.
- R2: Word offset 0 is the control word. Bit 15 is the match flag and bit 14 is the wrap flag. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A flag set by hardware in the same cycle wins over a clear.
- R3: When control bit 8 is 1 (periodic), a count step taken while the counter equals the compare value loads 0 and sets the match flag, so one period is compare value + 1 steps.
- R4: When bit 8 is 0 (free-running), a count step at compare equality sets the match flag without clearing the counter. A step from all ones wraps to 0 and sets the wrap flag.
- R5: Bits 5:4 select the request kind: 0 none, 1 DMA, 2 interrupt. `irq` is high while the match flag is set, bits 5:4 equal 2 and bit 7 is 1. `dma_req` is a one-cycle pulse in the cycle after each match step, issued only when bits 5:4 equal 1.
- R6: Bits 2:0 set the step rate in reference ticks per count step: code 4 is 8, code 5 is 32, code 6 is 128 and code 7 is 1. Codes 0 to 3 stop counting.
- R7: A write to word offset 1 (counter) is applied on the second reference tick after the write. Until then the read-back shows the old count. A new write restarts the wait.
- R8: While `run_bit` is 0 the counter holds its value. A 0-to-1 change of `run_bit` clears the prescaler, and the reference tick in that cycle is not counted.
- R9: Word offset 2 holds the compare value. A write to it is used for matching from the next cycle on. Offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per slow reference clock period |
| run_bit | input | 1 | This channel's bit of the shared start/stop register |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Word offset: 0 control, 1 counter, 2 compare |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, high while the match flag is pending |
| dma_req | output | 1 | One-cycle DMA request per match |

## Verification
The channel is first run periodically with a small compare value and a tick every cycle. This separates the restart at compare from a plain wrap and shows the level interrupt staying high. A free-running pass starts just below all ones, so the compare match and the all-ones wrap happen within a few steps of each other and the two flags can be told apart. Each divide code is then tried with the run bit toggled first. Any error in the prescaler clear or the divisor shows up as a wrong count. Counter writes use a sparse reference tick, which separates the staged write from an immediate one. The DMA and none request kinds, compare rewrites during counting, and flag clears written with ones and with zeros complete the set.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int unsigned CTL_W = 16;

  typedef enum logic [1:0] {
    REQ_OFF = 2'd0,
    REQ_DMA = 2'd1,
    REQ_IRQ = 2'd2,
    REQ_RSV = 2'd3
  } req_e;

  typedef struct packed {
    logic       periodic;
    logic       irq_en;
    req_e       req;
    logic [2:0] rate;
  } ctl_t;

  // reference ticks per count step; 0 means the code does not count
  function automatic int unsigned rate_divisor(input logic [2:0] code);
    int unsigned d;
    case (code)
      3'd4:    d = 8;
      3'd5:    d = 32;
      3'd6:    d = 128;
      3'd7:    d = 1;
      default: d = 0;
    endcase
    return d;
  endfunction

  // control word image as seen on the bus
  function automatic logic [CTL_W-1:0] ctl_image(input ctl_t c, input logic mflag,
                                                 input logic wflag);
    return {mflag, wflag, 5'b0, c.periodic, c.irq_en, 1'b0, c.req, 1'b0, c.rate};
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned MAX_DIV = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ref_tick,
  input  logic [2:0] rate,
  output logic       step
);
  localparam int unsigned PRE_W = $clog2(MAX_DIV);

  logic [PRE_W-1:0] pre_q;
  logic             run_q;
  logic             start_edge;
  logic             rate_ok;
  logic             hit;
  int unsigned      divisor;

  assign divisor    = cmt_pkg::rate_divisor(rate);
  assign rate_ok    = (divisor != 0);
  assign start_edge = run & ~run_q;
  assign hit        = (32'(pre_q) + 32'd1) >= divisor;
  assign step       = run & ~start_edge & ref_tick & rate_ok & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      if (start_edge) begin
        pre_q <= '0;
      end else if (run && ref_tick && rate_ok) begin
        pre_q <= hit ? '0 : pre_q + 1'b1;
      end
    end
  end

  // R6: steps only ever come from a reference tick while running
  a_r6_step_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (ref_tick && run));

  // R8: a start edge leaves the prescaler cleared
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_edge |=> (pre_q == '0));

endmodule

// File: rtl/cmt_load_sync.sv
module cmt_load_sync #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);
  localparam int unsigned TW = $clog2(SYNC_TICKS + 1);

  logic          pend_q;
  logic [TW-1:0] ticks_q;

  assign load = pend_q & ref_tick & ~wr & (ticks_q == TW'(SYNC_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      ticks_q  <= '0;
      load_val <= '0;
    end else if (wr) begin
      pend_q   <= 1'b1;
      ticks_q  <= '0;
      load_val <= wdata;
    end else if (load) begin
      pend_q  <= 1'b0;
      ticks_q <= '0;
    end else if (pend_q && ref_tick) begin
      ticks_q <= ticks_q + 1'b1;
    end
  end

  // R7: a fresh write is never applied in the very next cycle
  a_r7_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (SYNC_TICKS > 1)) |=> !load);

endmodule

// File: rtl/cmt_count_core.sv
module cmt_count_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp,
  input  logic             periodic,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_ev,
  output logic             wrap_ev
);

  function automatic logic [CNT_W-1:0] stepped(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] k,
                                               input logic per);
    return (per && (c == k)) ? '0 : c + 1'b1;
  endfunction

  logic at_cmp;
  logic at_top;

  assign at_cmp   = (cnt_q == cmp);
  assign at_top   = &cnt_q;
  assign match_ev = step & ~load & at_cmp;
  assign wrap_ev  = step & ~load & ~periodic & at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      cnt_q <= stepped(cnt_q, cmp, periodic);
    end
  end

  // R7: the staged value is what the counter shows after a load
  a_r7_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R3: a periodic match restarts at zero
  a_r3_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && periodic) |=> (cnt_q == '0));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned MAX_DIV    = 128,
  parameter int unsigned SYNC_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             run_bit,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq,
  output logic             dma_req
);
  import cmt_pkg::*;

  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_CMP = 2'd2;

  ctl_t             ctl_q;
  logic             cmf_q;
  logic             ovf_q;
  logic             dma_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             step;
  logic             match_ev;
  logic             wrap_ev;
  logic             wr_ctl;
  logic             wr_cnt;
  logic             wr_cmp;
  logic             clr_cmf;
  logic             clr_ovf;

  assign wr_ctl  = bus_sel & bus_wr & (bus_addr == A_CTL);
  assign wr_cnt  = bus_sel & bus_wr & (bus_addr == A_CNT);
  assign wr_cmp  = bus_sel & bus_wr & (bus_addr == A_CMP);
  assign clr_cmf = wr_ctl & ~bus_wdata[15];
  assign clr_ovf = wr_ctl & ~bus_wdata[14];

  cmt_prescaler #(.MAX_DIV(MAX_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_bit),
    .ref_tick (ref_tick),
    .rate     (ctl_q.rate),
    .step     (step)
  );

  cmt_load_sync #(.CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .wr       (wr_cnt),
    .wdata    (bus_wdata[CNT_W-1:0]),
    .load     (load),
    .load_val (load_val)
  );

  cmt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (load),
    .load_val (load_val),
    .cmp      (cmp_q),
    .periodic (ctl_q.periodic),
    .cnt_q    (cnt_q),
    .match_ev (match_ev),
    .wrap_ev  (wrap_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmf_q <= 1'b0;
      ovf_q <= 1'b0;
      dma_q <= 1'b0;
      cmp_q <= '1;
    end else begin
      if (wr_ctl) begin
        ctl_q.periodic <= bus_wdata[8];
        ctl_q.irq_en   <= bus_wdata[7];
        ctl_q.req      <= req_e'(bus_wdata[5:4]);
        ctl_q.rate     <= bus_wdata[2:0];
      end
      if (wr_cmp) cmp_q <= bus_wdata[CNT_W-1:0];
      cmf_q <= match_ev | (cmf_q & ~clr_cmf);
      ovf_q <= wrap_ev | (ovf_q & ~clr_ovf);
      dma_q <= match_ev & (ctl_q.req == REQ_DMA);
    end
  end

  assign irq     = cmf_q & ctl_q.irq_en & (ctl_q.req == REQ_IRQ);
  assign dma_req = dma_q;

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = BUS_W'(ctl_image(ctl_q, cmf_q, ovf_q));
      A_CNT:   bus_rdata = BUS_W'(cnt_q);
      A_CMP:   bus_rdata = BUS_W'(cmp_q);
      default: bus_rdata = '0;
    endcase
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{bus_wdata[13:9], bus_wdata[6], bus_wdata[3]};

  // R2: a flag rises only from a match step
  a_r2_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmf_q) |-> $past(match_ev));

  // R4: the wrap flag rises only from an all-ones wrap
  a_r4_wrap_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(wrap_ev));

  // R5: a DMA strobe always coincides with a pending match flag
  a_r5_dma_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> cmf_q);

  // R8: a stopped channel holds its count unless a staged write lands
  a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_bit && !load) |=> $stable(cnt_q));

endmodule

// File: tb/sim_cmt_channel.sv
module sim_cmt_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        run_bit = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        dma_req;

  always #4 clk = ~clk;

  cmt_channel u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run_bit(run_bit),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  int    gap = 1;
  int    gcnt = 0;

  // reference tick every `gap` clocks
  always @(negedge clk) begin
    if (gcnt + 1 >= gap) begin ref_tick <= 1'b1; gcnt <= 0; end
    else begin ref_tick <= 1'b0; gcnt <= gcnt + 1; end
  end

  // behavioural reference model
  logic [31:0] m_cnt, m_cmp, m_pval;
  bit m_mode, m_ie, m_cmf, m_ovf, m_dma, m_runp, m_pend;
  bit [1:0] m_req;
  bit [2:0] m_cks;
  int m_pre, m_pt;

  function automatic int ticks_per_step(bit [2:0] c);
    if (c == 3'd7) return 1;
    if (c == 3'd4) return 8;
    if (c == 3'd5) return 32;
    if (c == 3'd6) return 128;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 32'hFFFF_FFFF; m_pval = 0;
      m_mode = 0; m_ie = 0; m_cmf = 0; m_ovf = 0; m_dma = 0;
      m_runp = 0; m_pend = 0; m_req = 0; m_cks = 0; m_pre = 0; m_pt = 0;
    end else begin
      bit wr_any, w0, w1, w2, go, ld, mt, ov;
      int r;
      wr_any = bus_sel && bus_wr;
      w0 = wr_any && bus_addr == 0;
      w1 = wr_any && bus_addr == 1;
      w2 = wr_any && bus_addr == 2;
      r = ticks_per_step(m_cks);
      go = 0;
      if (run_bit && !m_runp) m_pre = 0;
      else if (run_bit && ref_tick && r > 0) begin
        if (m_pre + 1 >= r) begin go = 1; m_pre = 0; end
        else m_pre = m_pre + 1;
      end
      m_runp = run_bit;
      ld = 0;
      if (w1) begin m_pend = 1; m_pval = bus_wdata; m_pt = 0; end
      else if (m_pend && ref_tick) begin
        m_pt = m_pt + 1;
        if (m_pt == 2) begin ld = 1; m_pend = 0; m_pt = 0; end
      end
      mt = go && !ld && (m_cnt == m_cmp);
      ov = go && !ld && !m_mode && (m_cnt == 32'hFFFF_FFFF);
      m_dma = mt && (m_req == 2'd1);
      if (ld) m_cnt = m_pval;
      else if (go) m_cnt = (m_mode && mt) ? 32'd0 : m_cnt + 32'd1;
      if (w0) begin
        if (!bus_wdata[15]) m_cmf = 0;
        if (!bus_wdata[14]) m_ovf = 0;
        m_mode = bus_wdata[8]; m_ie = bus_wdata[7];
        m_req = bus_wdata[5:4]; m_cks = bus_wdata[2:0];
      end
      if (mt) m_cmf = 1;
      if (ov) m_ovf = 1;
      if (w2) m_cmp = bus_wdata;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [31:0] erd;
      case (bus_addr)
        2'd0: erd = {16'b0, m_cmf, m_ovf, 5'b0, m_mode, m_ie, 1'b0, m_req, 1'b0, m_cks};
        2'd1: erd = m_cnt;
        2'd2: erd = m_cmp;
        default: erd = 32'd0;
      endcase
      chk("rdata", bus_rdata, erd);
      chk("irq", {31'b0, irq}, {31'b0, m_cmf && m_ie && m_req == 2'd2});
      chk("dma_req", {31'b0, dma_req}, {31'b0, m_dma});
    end
  end

  task automatic bw(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, held;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    rd(0, v); chk("ctrl after reset", v, 32'h0);
    rd(1, v); chk("count after reset", v, 32'h0);
    rd(2, v); chk("compare after reset", v, 32'hFFFF_FFFF);
    rd(3, v); chk("offset 3 reads zero (R9)", v, 32'h0);
    chk("irq after reset", {31'b0, irq}, 32'h0);
    @(negedge clk);

    // R3 periodic with small compare, irq kind
    cur_req = "R3";
    bw(2, 32'd4);
    bw(0, 32'h0000_01A7);
    run_bit = 1;
    repeat (40) @(negedge clk);
    chk("irq held in periodic (R5)", {31'b0, irq}, 32'h1);

    // R2 flag clear semantics
    cur_req = "R2";
    run_bit = 0;
    @(negedge clk);
    bw(0, 32'h0000_81A7);
    rd(0, v); chk("flag kept by writing one", {31'b0, v[15]}, 32'h1);
    bw(0, 32'h0000_01A7);
    rd(0, v); chk("flag cleared by writing zero", {31'b0, v[15]}, 32'h0);
    chk("irq drops with flag", {31'b0, irq}, 32'h0);

    // R7 staged counter write with sparse ticks
    cur_req = "R7";
    gap = 5;
    bw(1, 32'hFFFF_FFF0);
    rd(1, v); chk("old count still visible", {31'b0, v == 32'hFFFF_FFF0}, 32'h0);
    repeat (14) @(negedge clk);
    rd(1, v); chk("staged count applied", v, 32'hFFFF_FFF0);

    // R4 free-running match and wrap
    cur_req = "R4";
    gap = 1;
    bw(2, 32'hFFFF_FFF8);
    bw(0, 32'h0000_00A7);
    run_bit = 1;
    repeat (30) @(negedge clk);
    run_bit = 0;
    @(negedge clk);
    rd(0, v); chk("wrap flag set", {30'b0, v[15:14]}, 32'h3);
    rd(1, v); chk("count past wrap is small", {31'b0, v < 32'd40}, 32'h1);
    bw(0, 32'h0000_00A7);

    // R5 DMA kind, then none kind
    cur_req = "R5";
    bw(1, 32'd0);
    repeat (4) @(negedge clk);
    bw(2, 32'd3);
    bw(0, 32'h0000_0117);
    run_bit = 1;
    repeat (40) @(negedge clk);
    chk("no irq in DMA kind", {31'b0, irq}, 32'h0);
    bw(0, 32'h0000_0107);
    repeat (20) @(negedge clk);
    run_bit = 0;
    @(negedge clk);

    // R6 divide codes, each measured from a start edge
    cur_req = "R6";
    bw(2, 32'hFFFF_FFFF);
    for (int k = 0; k < 5; k++) begin
      logic [2:0] code;
      logic [31:0] want;
      case (k)
        0: begin code = 3'd4; want = 32'd9;  end
        1: begin code = 3'd5; want = 32'd2;  end
        2: begin code = 3'd6; want = 32'd0;  end
        3: begin code = 3'd7; want = 32'd79; end
        default: begin code = 3'd2; want = 32'd0; end
      endcase
      bw(0, {29'b0, code} | 32'h0000_0100);
      bw(1, 32'd0);
      repeat (3) @(negedge clk);
      run_bit = 1;
      repeat (80) @(negedge clk);
      run_bit = 0;
      @(negedge clk);
      rd(1, v); chk($sformatf("count for rate code %0d", code), v, want);
    end
    bw(0, 32'h0000_0106);
    bw(1, 32'd0);
    repeat (3) @(negedge clk);
    run_bit = 1;
    repeat (300) @(negedge clk);
    run_bit = 0;
    @(negedge clk);
    rd(1, v); chk("count for code 6 over 299 ticks", v, 32'd2);

    // R8 freeze while stopped
    cur_req = "R8";
    bw(0, 32'h0000_0107);
    run_bit = 1;
    repeat (7) @(negedge clk);
    run_bit = 0;
    @(negedge clk);
    rd(1, held);
    repeat (10) @(negedge clk);
    rd(1, v); chk("count frozen while stopped", v, held);

    // R9 compare rewrite during counting
    cur_req = "R9";
    bw(0, 32'h0000_01A7);
    bw(1, 32'd0);
    bw(2, 32'd100);
    repeat (3) @(negedge clk);
    run_bit = 1;
    repeat (20) @(negedge clk);
    bw(2, 32'd30);
    repeat (20) @(negedge clk);
    run_bit = 0;
    @(negedge clk);
    rd(0, v); chk("match at rewritten compare", {31'b0, v[15]}, 32'h1);
    rd(1, v); chk("restarted below new compare", {31'b0, v < 32'd30}, 32'h1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule